// File: doc/BRIEF.md
# Dual-Write Dual-Read RAM with Per-Pair Write Forwarding

This block is a synchronous memory with two write ports and two read ports, all driven by one clock. Each write port carries an address, a data word and one enable bit per byte lane. A write happens whenever any of its lane enables is set. Each read port samples its address on a rising edge when its read enable is high, looks up the array and registers the result. The result appears on the port one edge later.

When a read and a write target the same address on the same edge, an elaboration-time bit matrix decides the outcome for that read/write pair. A pair marked as forwarding returns the freshly written lanes. A pair not marked returns the word as it was before the edge. Because the setting is chosen per pair, both read ports can forward from the same writer at once, and one read port can forward from one writer while ignoring the other. The bypass is plain logic: an address comparator, a per-lane multiplexer and the read output register. The block has no state machine; its only sequential elements are the array and the read output registers.

Top module: `mpram_fwd`

## Requirements
- R1: While `rst_n` is low, and after it rises, every `rd_data` word reads zero until a read is performed. Reset does not clear the array.
- R2: Lane `l` covers bits `[8l+7:8l]`. A write stores only the lanes whose `wr_be` bit is set, and the other lanes of that word keep their contents for later reads.
- R3: With `rd_en[r]` high on an edge and no forwarding write to the same address, `rd_data[r]` shows the stored word at `rd_addr[r]` from the next edge on.
- R4: With `rd_en[r]` low on an edge, `rd_data[r]` keeps its value, even when a forwarding write hits its address.
- R5: Bit `r*NWR+w` of `XPARENT` makes read port `r` forward from write port `w`. The default `4'b1011` makes read port 0 forward from both writers, and read port 1 forward from writer 1 only.
- R6: On a forwarding collision, the lanes enabled by the forwarding writer carry its new data, and the remaining lanes carry the stored data.
- R7: On a collision with a writer that is not set to forward, the read returns the word as stored before that edge.
- R8: When both writers enable the same lane of the same address on one edge, writer 1's data is stored.
- R9: When several forwarding writers enable the same lane at the read address, the read takes that lane from the highest-numbered one.
- R10: Two read ports can both forward from the same writer on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports |
| rst_n | input | 1 | Asynchronous active-low reset of the read output registers |
| wr_addr | input | NWR x ADDR_W | Write address per writer |
| wr_be | input | NWR x LANES | Lane enables per writer. A write occurs if any bit is set. |
| wr_data | input | NWR x DATA_W | Write data per writer |
| rd_en | input | NRD | Read enable per reader |
| rd_addr | input | NRD x ADDR_W | Read address per reader |
| rd_data | output | NRD x DATA_W | Registered read data per reader |

## Verification
Every read result, whether it comes from the array or is forwarded, is due exactly one rising edge after the edge that sampled `rd_en`. A write becomes visible to plain reads sampled on any later edge. The bench drives a full set of inputs at a falling edge and computes the expected words from its own model before that model takes the writes. It then waits for the rising edge and compares at the following falling edge. A port whose enable was low is expected to repeat its previous word. Random traffic is confined to four addresses so that collisions between writers, and between readers and writers, occur often.

// File: rtl/mpram_fwd_pkg.sv
package mpram_fwd_pkg;
    localparam int MAX_PORTS = 8;

    // True when port w is the only active writer in the activity vector.
    function automatic logic lone_writer(input logic [MAX_PORTS-1:0] act, input int w);
        logic [MAX_PORTS-1:0] one;
        one = '0;
        one[w] = 1'b1;
        return act == one;
    endfunction
endpackage

// File: rtl/mpram_store.sv
module mpram_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int LANES  = 4,
    parameter int NWR    = 2,
    parameter int NRD    = 2,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LW     = DATA_W / LANES
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NWR-1:0][ADDR_W-1:0]         wr_addr,
    input  logic [NWR-1:0][LANES-1:0]          wr_be,
    input  logic [NWR-1:0][DATA_W-1:0]         wr_data,
    input  logic [NRD-1:0][ADDR_W-1:0]         rd_addr,
    output logic [NRD-1:0][DATA_W-1:0]         old_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Later ports are written last, so they win a shared lane.
    always_ff @(posedge clk) begin
        for (int w = 0; w < NWR; w++) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_be[w][l]) begin
                    mem[wr_addr[w]][l*LW +: LW] <= wr_data[w][l*LW +: LW];
                end
            end
        end
    end

    // Read happens against the array at the sampling edge.
    always_comb begin
        for (int r = 0; r < NRD; r++) begin
            old_data[r] = mem[rd_addr[r]];
        end
    end

    assert_wr_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_be[0] == '1 && wr_be[NWR-1] == '1 && wr_addr[0] == wr_addr[NWR-1])
        |=> mem[$past(wr_addr[0])] == $past(wr_data[NWR-1]));
endmodule

// File: rtl/mpram_bypass.sv
module mpram_bypass
    import mpram_fwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int LANES  = 4,
    parameter int NWR    = 2,
    parameter logic [NWR-1:0] XP_ROW = '1,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LW     = DATA_W / LANES
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               rd_en,
    input  logic [ADDR_W-1:0]                  rd_addr,
    input  logic [DATA_W-1:0]                  old_data,
    input  logic [NWR-1:0][ADDR_W-1:0]         wr_addr,
    input  logic [NWR-1:0][LANES-1:0]          wr_be,
    input  logic [NWR-1:0][DATA_W-1:0]         wr_data,
    output logic [DATA_W-1:0]                  rd_q
);
    logic [DATA_W-1:0] merged;

    // Per-lane merge; a higher forwarding writer overrides a lower one.
    always_comb begin
        merged = old_data;
        for (int w = 0; w < NWR; w++) begin
            for (int l = 0; l < LANES; l++) begin
                if (XP_ROW[w] && wr_be[w][l] && wr_addr[w] == rd_addr) begin
                    merged[l*LW +: LW] = wr_data[w][l*LW +: LW];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= merged;
        end
    end

    // Checker-side view of which writers are active this edge.
    logic [MAX_PORTS-1:0] wr_act;
    always_comb begin
        wr_act = '0;
        for (int w = 0; w < NWR; w++) begin
            wr_act[w] = |wr_be[w];
        end
    end

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rd_q == '0);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_q));

    assert_plain_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_act == '0) |=> rd_q == $past(old_data));

    generate
        for (genvar w = 0; w < NWR; w++) begin : g_pair
            if (!XP_ROW[w]) begin : g_opaque
                assert_old_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    (rd_en && lone_writer(wr_act, w))
                    |=> rd_q == $past(old_data));
            end else if (w == NWR - 1) begin : g_top_fwd
                assert_forward_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
                    (rd_en && wr_be[w] == '1 && wr_addr[w] == rd_addr)
                    |=> rd_q == $past(wr_data[w]));
            end
        end
    endgenerate
endmodule

// File: rtl/mpram_fwd.sv
module mpram_fwd #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int LANES  = 4,
    parameter int NWR    = 2,
    parameter int NRD    = 2,
    parameter logic [NRD*NWR-1:0] XPARENT = 4'b1011,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NWR-1:0][ADDR_W-1:0]         wr_addr,
    input  logic [NWR-1:0][LANES-1:0]          wr_be,
    input  logic [NWR-1:0][DATA_W-1:0]         wr_data,
    input  logic [NRD-1:0]                     rd_en,
    input  logic [NRD-1:0][ADDR_W-1:0]         rd_addr,
    output logic [NRD-1:0][DATA_W-1:0]         rd_data
);
    logic [NRD-1:0][DATA_W-1:0] old_data;

    mpram_store #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .LANES(LANES), .NWR(NWR), .NRD(NRD)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_addr (wr_addr),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .old_data(old_data)
    );

    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            mpram_bypass #(
                .DATA_W(DATA_W), .DEPTH(DEPTH), .LANES(LANES), .NWR(NWR),
                .XP_ROW(XPARENT[r*NWR +: NWR])
            ) u_byp (
                .clk     (clk),
                .rst_n   (rst_n),
                .rd_en   (rd_en[r]),
                .rd_addr (rd_addr[r]),
                .old_data(old_data[r]),
                .wr_addr (wr_addr),
                .wr_be   (wr_be),
                .wr_data (wr_data),
                .rd_q    (rd_data[r])
            );
        end
    endgenerate
endmodule

// File: tb/tb_mpram_fwd.sv
`timescale 1ns/1ps
module tb_mpram_fwd;
    localparam int DW = 32, DEP = 16, LN = 4, NW = 2, NR = 2, AW = 4;
    localparam logic [3:0] XP = 4'b1011; // per R5

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NW-1:0][AW-1:0] wr_addr = '0;
    logic [NW-1:0][LN-1:0] wr_be = '0;
    logic [NW-1:0][DW-1:0] wr_data = '0;
    logic [NR-1:0]         rd_en = '0;
    logic [NR-1:0][AW-1:0] rd_addr = '0;
    logic [NR-1:0][DW-1:0] rd_data;

    logic [DW-1:0] ref_mem [DEP];
    logic [DW-1:0] held [NR];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mpram_fwd dut (.clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_be(wr_be),
                   .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

    function automatic logic [DW-1:0] model_rd(int r);
        logic [DW-1:0] v = ref_mem[rd_addr[r]];
        for (int w = 0; w < NW; w++)
            for (int l = 0; l < LN; l++)
                if (XP[r*NW+w] && wr_be[w][l] && wr_addr[w] == rd_addr[r])
                    v[l*8 +: 8] = wr_data[w][l*8 +: 8];
        return v;
    endfunction

    function automatic bit fwd_hit(int r, int w);
        return XP[r*NW+w] && (wr_be[w] != '0) && wr_addr[w] == rd_addr[r];
    endfunction

    function automatic string classify(int r);
        bit any_fwd = 0, any_col = 0, shared = 1;
        if (!rd_en[r]) return "R4";
        for (int w = 0; w < NW; w++) begin
            if (fwd_hit(r, w)) any_fwd = 1;
            if (wr_be[w] != '0 && wr_addr[w] == rd_addr[r]) any_col = 1;
        end
        if (fwd_hit(r, 0) && fwd_hit(r, 1) && ((wr_be[0] & wr_be[1]) != '0)) return "R9";
        if (any_fwd) begin
            for (int q = 0; q < NR; q++) if (!rd_en[q] || !fwd_hit(q, 1)) shared = 0;
            return shared ? "R10" : "R6";
        end
        if (any_col) return "R7";
        return "R3";
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Inputs are already driven (at a falling edge); apply one edge and compare.
    task automatic step(string tag);
        logic [DW-1:0] exp [NR];
        string tg [NR];
        for (int r = 0; r < NR; r++) begin
            exp[r] = rd_en[r] ? model_rd(r) : held[r];
            tg[r]  = (tag != "") ? tag : classify(r);
        end
        for (int w = 0; w < NW; w++)
            for (int l = 0; l < LN; l++)
                if (wr_be[w][l]) ref_mem[wr_addr[w]][l*8 +: 8] = wr_data[w][l*8 +: 8];
        @(posedge clk);
        @(negedge clk);
        for (int r = 0; r < NR; r++) begin
            check(tg[r], rd_data[r], exp[r]);
            held[r] = exp[r];
        end
    endtask

    task automatic idle();
        wr_be = '0;
        rd_en = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int r = 0; r < NR; r++) held[r] = '0;
        repeat (3) @(negedge clk);
        for (int r = 0; r < NR; r++) check("R1", rd_data[r], '0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int r = 0; r < NR; r++) check("R1", rd_data[r], '0);

        // Fill the array through writer 0; readers stay disabled (R4 hold).
        for (int a = 0; a < DEP; a++) begin
            idle();
            wr_be[0] = '1;
            wr_addr[0] = AW'(a);
            wr_data[0] = 32'hA000_0000 + 32'(a) * 32'h0101_0101;
            step("R4");
        end

        // R2: lane 1 only, then read back.
        idle(); wr_be[0] = 4'b0010; wr_addr[0] = 4'd3; wr_data[0] = 32'h1122_3344;
        step("R2");
        idle(); rd_en = 2'b11; rd_addr[0] = 4'd3; rd_addr[1] = 4'd3;
        step("R2");

        // R8: both writers full on address 5, then read.
        idle(); wr_be = '1; wr_addr[0] = 4'd5; wr_addr[1] = 4'd5;
        wr_data[0] = 32'hDEAD_0000; wr_data[1] = 32'hBEEF_1111;
        step("R8");
        idle(); rd_en = 2'b01; rd_addr[0] = 4'd5;
        step("R8");

        // R5: writer 0 collides with both readers; reader 1 must see old data.
        idle(); wr_be[0] = '1; wr_addr[0] = 4'd6; wr_data[0] = 32'h5555_AAAA;
        rd_en = 2'b11; rd_addr[0] = 4'd6; rd_addr[1] = 4'd6;
        step("R5");

        // R10: writer 1 forwards to both readers, partial lanes (R6 merge too).
        idle(); wr_be[1] = 4'b1001; wr_addr[1] = 4'd7; wr_data[1] = 32'h7777_7777;
        rd_en = 2'b11; rd_addr[0] = 4'd7; rd_addr[1] = 4'd7;
        step("R10");

        // R9: both writers hit reader 0's address on overlapping lanes.
        idle(); wr_be[0] = 4'b0111; wr_be[1] = 4'b0110; wr_addr[0] = 4'd8; wr_addr[1] = 4'd8;
        wr_data[0] = 32'h0000_0000; wr_data[1] = 32'hFFFF_FFFF;
        rd_en = 2'b01; rd_addr[0] = 4'd8;
        step("R9");

        // R4: forwarding write while reader disabled.
        idle(); wr_be[1] = '1; wr_addr[1] = rd_addr[0]; wr_data[1] = 32'h0BAD_0BAD;
        step("R4");

        // Random collisions on a small address window.
        for (int i = 0; i < 3000; i++) begin
            for (int w = 0; w < NW; w++) begin
                wr_addr[w] = AW'($urandom % 4);
                wr_be[w]   = LN'($urandom);
                wr_data[w] = $urandom;
            end
            for (int r = 0; r < NR; r++) begin
                rd_en[r]   = ($urandom % 4) != 0;
                rd_addr[r] = AW'($urandom % 4);
            end
            step("");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule